// File: doc/BRIEF.md
# Software-Partitioned Data Cache Region Controller

This controller sits in front of two on-chip data caches: a small direct-mapped mini-cache and a set-associative main cache whose ways can each be handed out on their own. Every load or store arrives with a region code that software derived from an annotation on the instruction. The code points the access at the mini-cache, at a mask of main-cache ways, or past both caches to memory. Only the arrays inside the chosen region are switched on. Lookup, refill and victim choice all stay inside that region, so a data type that software confined to two ways never disturbs the others.

The controller keeps the tag, valid and dirty state for both caches and a per-set round-robin pointer for the main cache. It reports which data arrays are enabled and how many, for every access. Both caches are write-back. Dirty victims and bypassed stores go into a small write buffer. That buffer folds stores to the same block into one entry and drains in order to the next memory level. Refill and bypassed-read requests are issued as single-cycle pulses. The timing of the memory behind them lies outside this block.

Top module: `region_cache_ctrl`

## Requirements
- R1: The region code on `req_region` decodes as 0 for the mini-cache, 1 for the way mask on `req_mask`, and 2 or 3 for bypass. Code 1 with an all-zero mask is handled as bypass.
- R2: A mini-cache access raises only `mini_en` and gives `en_count` 1. A way access raises `way_en` equal to the mask and gives `en_count` the number of set mask bits. A bypass access enables no array and gives `en_count` 0. With no accepted request, every enable is low.
- R3: A hit is reported only when the block is valid in the mini-cache (code 0) or in a way inside the mask (code 1). A block held only in a way outside the mask is a miss.
- R4: A bypassed read raises `byp_rd_valid` with the request address in the same cycle and allocates nothing: a later cached access to that block still misses.
- R5: On a main-cache miss, the refill way is the first way in the mask found by searching upward, cyclically, from that set's round-robin pointer. The pointer then moves to the way after the victim. `fill_way` is one-hot in that way.
- R6: A store that hits marks the line dirty and sends nothing to memory. A store that misses allocates the line as dirty. A miss that evicts a dirty line (from either cache) pushes the victim's block address with a full word mask into the write buffer in the same cycle that the refill pulse is raised.
- R7: A bypassed store sets word-mask bit `req_addr[1:0]` of a buffer entry. If an entry for the same block is waiting and is not being drained in that cycle, the store merges into it instead of taking a new entry.
- R8: When the write buffer is full, an access that needs a new entry sees `req_ready` low and changes no state. An access that merges, or that needs no entry, is still accepted.
- R9: The buffer presents its oldest entry on `wb_valid`/`wb_addr`/`wb_mask` and holds it while `wb_ready` is low. Entries leave in arrival order.
- R10: After reset, no line is valid, every round-robin pointer is 0, and the write buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | AW | Word address |
| req_region | input | 2 | Region code (R1) |
| req_mask | input | WAYS | Main-cache way mask for code 1 |
| req_ready | output | 1 | Low when the access must be retried (R8) |
| hit | output | 1 | Accepted cached access hit |
| mini_en | output | 1 | Mini-cache arrays enabled |
| way_en | output | WAYS | Main-cache way arrays enabled |
| en_count | output | clog2(WAYS+1) | Number of enabled arrays |
| fill_valid | output | 1 | Refill request pulse |
| fill_addr | output | AW-2 | Block address to refill |
| fill_way | output | WAYS | One-hot refill way, zero for mini-cache refills |
| byp_rd_valid | output | 1 | Bypassed read request pulse |
| byp_rd_addr | output | AW | Bypassed read word address |
| wb_valid | output | 1 | Write buffer head valid |
| wb_addr | output | AW-2 | Head block address |
| wb_mask | output | 4 | Head word mask |
| wb_ready | input | 1 | Memory takes the head entry |

## Verification
Tags, valid bits and dirty bits cannot be read out directly. A wrong internal state therefore appears at the ports only when a later access uses it. A bad round-robin pointer shows up as the wrong `fill_way` on the next miss in that set. A tag written to the wrong way turns an expected hit into a refill pulse on the very next access. A lost dirty bit means no victim entry appears on `wb_valid` one cycle after the evicting miss. A mis-merged store shows up as an extra entry, or a wrong `wb_mask`, as soon as that entry reaches the head. The directed scenarios are built so that each such error surfaces within a few accesses of its cause.

// File: rtl/region_cache_ctrl.sv
module region_cache_ctrl #(
  parameter int AW    = 16,
  parameter int WORDS = 4,
  parameter int SETS  = 16,
  parameter int MSETS = 8,
  parameter int WAYS  = 4,
  parameter int WBD   = 4,
  localparam int OFF  = $clog2(WORDS),
  localparam int BA   = AW - OFF,
  localparam int EW   = $clog2(WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_region,
  input  logic [WAYS-1:0]  req_mask,
  output logic             req_ready,
  output logic             hit,
  output logic             mini_en,
  output logic [WAYS-1:0]  way_en,
  output logic [EW-1:0]    en_count,
  output logic             fill_valid,
  output logic [BA-1:0]    fill_addr,
  output logic [WAYS-1:0]  fill_way,
  output logic             byp_rd_valid,
  output logic [AW-1:0]    byp_rd_addr,
  output logic             wb_valid,
  output logic [BA-1:0]    wb_addr,
  output logic [WORDS-1:0] wb_mask,
  input  logic             wb_ready
);
  localparam int IB  = $clog2(SETS);
  localparam int MIB = $clog2(MSETS);
  localparam int TB  = BA - IB;
  localparam int MTB = BA - MIB;
  localparam int WPB = $clog2(WAYS);
  localparam int WBP = $clog2(WBD);

  logic [TB-1:0]    wtag  [WAYS][SETS];
  logic [SETS-1:0]  wval  [WAYS];
  logic [SETS-1:0]  wdirty[WAYS];
  logic [WPB-1:0]   rr    [SETS];
  logic [MTB-1:0]   mtag  [MSETS];
  logic [MSETS-1:0] mval, mdirty;

  logic [BA-1:0]    wba [WBD];
  logic [WORDS-1:0] wbm [WBD];
  logic [WBD-1:0]   wbv;
  logic [WBP-1:0]   rd, wr;
  logic [WBP:0]     cnt;

  wire [BA-1:0]  blk  = req_addr[AW-1:OFF];
  wire [IB-1:0]  idx  = blk[IB-1:0];
  wire [TB-1:0]  tag  = blk[BA-1:IB];
  wire [MIB-1:0] midx = blk[MIB-1:0];
  wire [MTB-1:0] mt   = blk[BA-1:MIB];

  wire is_mini = req_region == 2'd0;
  wire is_way  = req_region == 2'd1 && |req_mask;
  wire is_byp  = !is_mini && !is_way;

  logic [WAYS-1:0] way_hit;
  logic [WPB-1:0]  vway;
  logic            vfound;
  always_comb begin
    for (int w = 0; w < WAYS; w++)
      way_hit[w] = req_mask[w] && wval[w][idx] && wtag[w][idx] == tag;
    vway = '0;
    vfound = 1'b0;
    for (int k = 0; k < WAYS; k++)
      if (!vfound && req_mask[WPB'(rr[idx] + WPB'(k))]) begin
        vway = WPB'(rr[idx] + WPB'(k));
        vfound = 1'b1;
      end
  end

  wire m_hit = mval[midx] && mtag[midx] == mt;
  wire miss  = (is_way && !(|way_hit)) || (is_mini && !m_hit);
  wire vdirty = is_mini ? (mval[midx] && mdirty[midx])
                        : (wval[vway][idx] && wdirty[vway][idx]);
  wire [BA-1:0] vaddr = is_mini ? {mtag[midx], midx} : {wtag[vway][idx], idx};

  wire             push_need = req_valid && ((is_byp && req_write) || (miss && vdirty));
  wire [BA-1:0]    push_addr = is_byp ? blk : vaddr;
  wire [WORDS-1:0] push_mask = is_byp ? (WORDS'(1) << req_addr[OFF-1:0]) : '1;
  wire             drain = wbv[rd] && wb_ready;
  wire             full  = cnt == (WBP+1)'(WBD);

  logic           mfound;
  logic [WBP-1:0] mi;
  always_comb begin
    mfound = 1'b0;
    mi = '0;
    for (int i = 0; i < WBD; i++)
      if (!mfound && wbv[i] && wba[i] == push_addr && !(drain && WBP'(i) == rd)) begin
        mfound = 1'b1;
        mi = WBP'(i);
      end
  end

  assign req_ready = !(push_need && !mfound && full);
  wire go   = req_valid && req_ready;
  wire push = go && push_need;

  assign hit          = go && !is_byp && !miss;
  assign mini_en      = go && is_mini;
  assign way_en       = (go && is_way) ? req_mask : '0;
  assign fill_valid   = go && miss;
  assign fill_addr    = blk;
  assign fill_way     = (go && is_way && miss) ? (WAYS'(1) << vway) : '0;
  assign byp_rd_valid = go && is_byp && !req_write;
  assign byp_rd_addr  = req_addr;
  assign wb_valid     = wbv[rd];
  assign wb_addr      = wba[rd];
  assign wb_mask      = wbm[rd];

  always_comb begin
    en_count = EW'(mini_en);
    for (int w = 0; w < WAYS; w++) en_count = en_count + EW'(way_en[w]);
  end

  always_ff @(posedge clk) begin
    if (go && is_way && miss) wtag[vway][idx] <= tag;
    if (go && is_mini && miss) mtag[midx] <= mt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        wval[w]   <= '0;
        wdirty[w] <= '0;
      end
      for (int s = 0; s < SETS; s++) rr[s] <= '0;
      mval   <= '0;
      mdirty <= '0;
    end else if (go) begin
      if (is_way && miss) begin
        wval[vway][idx]   <= 1'b1;
        wdirty[vway][idx] <= req_write;
        rr[idx]           <= vway + WPB'(1);
      end else if (is_way && req_write) begin
        for (int w = 0; w < WAYS; w++)
          if (way_hit[w]) wdirty[w][idx] <= 1'b1;
      end
      if (is_mini) begin
        if (miss) begin
          mval[midx]   <= 1'b1;
          mdirty[midx] <= req_write;
        end else if (req_write) mdirty[midx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbv <= '0;
      rd  <= '0;
      wr  <= '0;
      cnt <= '0;
      for (int i = 0; i < WBD; i++) begin
        wba[i] <= '0;
        wbm[i] <= '0;
      end
    end else begin
      if (drain) begin
        wbv[rd] <= 1'b0;
        rd <= rd + WBP'(1);
      end
      if (push) begin
        if (mfound) wbm[mi] <= wbm[mi] | push_mask;
        else begin
          wbv[wr] <= 1'b1;
          wba[wr] <= push_addr;
          wbm[wr] <= push_mask;
          wr <= wr + WBP'(1);
        end
      end
      cnt <= cnt + (WBP+1)'(push && !mfound) - (WBP+1)'(drain);
    end
  end
endmodule

// File: rtl/region_cache_ctrl_chk.sv
module region_cache_ctrl_chk #(
  parameter int AW    = 16,
  parameter int WORDS = 4,
  parameter int WAYS  = 4,
  localparam int BA   = AW - $clog2(WORDS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [WAYS-1:0] req_mask,
  input logic            req_ready,
  input logic            hit,
  input logic            mini_en,
  input logic [WAYS-1:0] way_en,
  input logic            fill_valid,
  input logic [WAYS-1:0] fill_way,
  input logic            byp_rd_valid,
  input logic            wb_valid,
  input logic [BA-1:0]   wb_addr,
  input logic            wb_ready
);
  a_r2_enables_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    ((way_en & ~req_mask) == '0) && (mini_en -> way_en == '0));

  a_r4_bypass_touches_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    byp_rd_valid |-> !mini_en && way_en == '0 && !fill_valid && !hit);

  a_r5_fill_way_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (|fill_way) |-> fill_valid && $onehot(fill_way) && (fill_way & ~req_mask) == '0);

  a_r3_hit_excludes_fill: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !fill_valid);

  a_r8_stall_needs_entries: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> wb_valid);

  a_r9_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
endmodule

bind region_cache_ctrl region_cache_ctrl_chk #(.AW(AW), .WORDS(WORDS), .WAYS(WAYS)) chk_i (.*);

// File: tb/region_cache_ctrl_tb.sv
module region_cache_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, wb_ready = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_region = '0;
  logic [3:0]  req_mask = '0;
  logic req_ready, hit, mini_en, fill_valid, byp_rd_valid, wb_valid;
  logic [3:0] way_en, fill_way, wb_mask;
  logic [2:0] en_count;
  logic [13:0] fill_addr, wb_addr;
  logic [15:0] byp_rd_addr;

  int checks = 0, fails = 0;
  logic c_ready, c_hit, c_mini, c_fill, c_byp;
  logic [3:0] c_way, c_fway;
  logic [2:0] c_cnt;

  always #5 clk = ~clk;

  region_cache_ctrl dut_i (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int t, input int s, input int wd);
    return 16'((t << 6) | (s << 2) | wd);
  endfunction

  task automatic acc(input logic wr, input logic [15:0] a, input logic [1:0] rg, input logic [3:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_region = rg; req_mask = m;
    #1;
    c_ready = req_ready; c_hit = hit; c_mini = mini_en; c_fill = fill_valid;
    c_byp = byp_rd_valid; c_way = way_en; c_fway = fill_way; c_cnt = en_count;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain_one(input int a, input int m, input string req);
    @(negedge clk);
    chk(wb_valid == 1'b1, req, wb_valid, 1);
    chk(wb_addr == 14'(a), req, wb_addr, a);
    chk(wb_mask == 4'(m), req, wb_mask, m);
    wb_ready = 1'b1;
    @(posedge clk);
    #1 wb_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready && !wb_valid && en_count == 0 && !hit, "R10 idle after reset", {req_ready, wb_valid}, 2);
    acc(0, mk(1, 0, 0), 2'd1, 4'b1111);
    chk(c_fill && !c_hit, "R10 no valid line", c_fill, 1);
    chk(c_fway == 4'b0001, "R10 pointer starts at way 0", c_fway, 1);
    acc(0, mk(1, 1, 0), 2'd0, 4'b0000);
    chk(c_fill && !c_hit, "R10 mini empty", c_fill, 1);
  endtask

  task automatic t_mini;
    acc(0, mk(2, 1, 0), 2'd0, 4'b1111);
    chk(c_fill && c_fway == 0, "R3 mini miss on tag mismatch", c_fill, 1);
    acc(0, mk(2, 1, 3), 2'd0, 4'b1111);
    chk(c_hit && !c_fill, "R3 mini hit", c_hit, 1);
    chk(c_mini && c_way == 0 && c_cnt == 1, "R2 mini enables one array", c_cnt, 1);
  endtask

  task automatic t_round_robin;
    acc(0, mk(1, 3, 0), 2'd1, 4'b0110);
    chk(c_fway == 4'b0010, "R5 first fill way1", c_fway, 2);
    chk(c_way == 4'b0110 && c_cnt == 2 && !c_mini, "R2 two ways enabled", c_cnt, 2);
    acc(0, mk(2, 3, 0), 2'd1, 4'b0110);
    chk(c_fway == 4'b0100, "R5 second fill way2", c_fway, 4);
    acc(0, mk(3, 3, 0), 2'd1, 4'b0110);
    chk(c_fway == 4'b0010, "R5 wrap skips unmasked ways", c_fway, 2);
    acc(0, mk(2, 3, 1), 2'd1, 4'b0110);
    chk(c_hit && !c_fill, "R3 hit inside mask", c_hit, 1);
    acc(0, mk(3, 3, 0), 2'd1, 4'b0100);
    chk(!c_hit && c_fill, "R3 line outside mask misses", c_hit, 0);
    chk(c_fway == 4'b0100 && c_cnt == 1, "R5 single-way mask victim", c_fway, 4);
  endtask

  task automatic t_bypass;
    acc(0, mk(5, 6, 0), 2'd1, 4'b0000);
    chk(c_byp && c_cnt == 0 && !c_fill && c_way == 0, "R1 zero mask is bypass", c_byp, 1);
    acc(0, mk(5, 6, 1), 2'd3, 4'b1111);
    chk(c_byp && c_cnt == 0 && !c_mini, "R1 code 3 is bypass", c_byp, 1);
    acc(0, mk(7, 2, 0), 2'd2, 4'b1111);
    chk(c_byp && !c_fill, "R4 bypass read issued", c_byp, 1);
    acc(0, mk(7, 2, 0), 2'd0, 4'b0000);
    chk(c_fill && !c_hit, "R4 bypass did not allocate", c_hit, 0);
    chk(!wb_valid, "R4 reads leave buffer empty", wb_valid, 0);
  endtask

  task automatic t_writeback;
    acc(1, mk(1, 5, 0), 2'd1, 4'b0001);
    chk(c_fill, "R6 store miss allocates", c_fill, 1);
    acc(1, mk(1, 5, 2), 2'd1, 4'b0001);
    chk(c_hit && !wb_valid, "R6 store hit stays on chip", wb_valid, 0);
    acc(0, mk(2, 5, 0), 2'd1, 4'b0001);
    chk(c_fill, "R6 refill on dirty eviction", c_fill, 1);
    drain_one(14'h015, 4'hf, "R6 dirty way victim pushed");
    acc(1, mk(3, 4, 0), 2'd0, 4'b0000);
    acc(0, mk(4, 4, 0), 2'd0, 4'b0000);
    drain_one(14'h034, 4'hf, "R6 dirty mini victim pushed");
    @(negedge clk);
    chk(!wb_valid, "R9 buffer empty after drains", wb_valid, 0);
  endtask

  task automatic t_merge;
    acc(1, mk(9, 0, 0), 2'd2, 4'b0000);
    acc(1, mk(9, 0, 2), 2'd2, 4'b0000);
    acc(1, mk(9, 1, 1), 2'd2, 4'b0000);
    chk(c_ready && !c_byp, "R7 bypass store accepted", c_ready, 1);
    drain_one(14'h090, 4'b0101, "R7 merged entry");
    drain_one(14'h091, 4'b0010, "R7 second block own entry");
    @(negedge clk);
    chk(!wb_valid, "R7 only two entries", wb_valid, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) acc(1, mk(10, i, 0), 2'd2, 4'b0000);
    acc(1, mk(10, 4, 0), 2'd2, 4'b0000);
    chk(!c_ready, "R8 stall when full", c_ready, 0);
    acc(1, mk(10, 0, 3), 2'd2, 4'b0000);
    chk(c_ready, "R8 merge accepted when full", c_ready, 1);
    acc(0, mk(11, 7, 0), 2'd0, 4'b0000);
    chk(c_ready && c_fill, "R8 non-pushing access accepted when full", c_ready, 1);
    @(negedge clk);
    @(negedge clk);
    chk(wb_addr == 14'h0a0, "R9 head held", wb_addr, 14'h0a0);
    drain_one(14'h0a0, 4'b1001, "R9 oldest first");
    acc(1, mk(10, 4, 0), 2'd2, 4'b0000);
    chk(c_ready, "R8 retry after drain", c_ready, 1);
    for (int i = 1; i < 5; i++) drain_one(14'h0a0 + i, 4'b0001, "R9 order");
    @(negedge clk);
    chk(!wb_valid, "R9 empty at end", wb_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_mini();
    t_round_robin();
    t_bypass();
    t_writeback();
    t_merge();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule